// File: doc/BRIEF.md
# Flash Readout Protection Controller

This block guards an on-chip flash against unwanted readout and reprogramming. It keeps one 8-bit protection byte and turns it into an active protection level: none, level 1 or level 2. Every read, program or erase request from the host side passes through the block. The block either forwards the request as a registered strobe to the flash, or refuses it with a one-cycle denial pulse.

Protection is judged against the current access mode: user, parallel I/O, serial I/O or an auxiliary mode. A two-bit removal field inside the byte cancels both protection fields when it holds 00. Once any protection is active, that removal field cannot be altered through the parallel port. The byte then has to be changed from one of the other modes. A tester-access qualifier marks readout attempts from production test equipment, and only level 2 turns those away.

Top module: `flash_guard`

## Requirements
- R1: After reset the protection byte reads 0xFF, `level_o` is 0, and no strobe, denial or write-reject pulse is asserted.
- R2: Bits 7:6 hold the first protection field and bits 3:2 the second; a field requests its level unless both of its bits are 1. `level_o` reports 0 for none, 1 for level 1 and 2 for level 2, and level 2 is reported when both fields request.
- R3: When bits 5:4 (the removal field) are 00, `level_o` is 0 whatever the two protection fields hold.
- R4: With `mode_i` = 1 (parallel) and `level_o` nonzero, every request is refused. Modes 0 (user), 2 (serial) and 3 (auxiliary) are not subject to this rule.
- R5: At level 2, a read request with `req_tester_i` high is refused in every mode. At level 1 alone such a read is forwarded in non-parallel modes.
- R6: A refused request raises `deny_o` for exactly the following cycle, issues no flash strobe, and `rsp_rdata_o` is 0xFF.
- R7: An accepted request raises the strobe for its op code (0 read, 1 program, 2 erase) in the following cycle, with `fl_addr_o` holding the request address and, for a program, `fl_wdata_o` holding the data. During a read strobe `rsp_rdata_o` returns `fl_rdata_i`. Op code 3 is always refused.
- R8: A write with `mode_i` = 1 while `level_o` is nonzero is rejected when its bits 5:4 differ from the stored ones: the byte keeps its value and `cfg_rej_o` pulses the next cycle. Every other write is stored and visible on `ctrl_o` and `level_o` the next cycle.
- R9: A stored write always has bits 1:0 set to 1, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Access mode: 0 user, 1 parallel, 2 serial, 3 auxiliary |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | Operation: 0 read, 1 program, 2 erase, 3 invalid |
| req_addr_i | input | ADDR_W | Flash address of the request |
| req_wdata_i | input | DATA_W | Program data |
| req_tester_i | input | 1 | Request originates from production test equipment |
| cfg_we_i | input | 1 | Write strobe for the protection byte |
| cfg_wdata_i | input | 8 | New protection byte value |
| fl_rdata_i | input | DATA_W | Read data returned by the flash |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_prog_o | output | 1 | Flash program strobe |
| fl_erase_o | output | 1 | Flash erase strobe |
| fl_addr_o | output | ADDR_W | Address presented with a strobe |
| fl_wdata_o | output | DATA_W | Program data presented with a program strobe |
| rsp_rdata_o | output | DATA_W | Read response, 0xFF unless a read strobe is active |
| deny_o | output | 1 | Request refused (one-cycle pulse) |
| cfg_rej_o | output | 1 | Protection byte write rejected (one-cycle pulse) |
| ctrl_o | output | 8 | Stored protection byte |
| level_o | output | 2 | Active protection level |

## Verification
A corrupted protection byte shows up at once on `ctrl_o` and `level_o`, and in the very next request cycle as a strobe where a denial was due, or the reverse. A wrong lock decision on the removal field is visible one cycle after the write, through the stored byte and the reject pulse. A later parallel-mode read then confirms whether the flash really opened. Each request is checked one cycle after it is issued, which is where a fault in the gate first appears.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  localparam int          CB_W     = 8;
  localparam logic [7:0]  CB_RESET = 8'hFF;
  localparam logic [7:0]  RSV_MASK = 8'h03;
  localparam int          L1_LSB   = 6;
  localparam int          RM_LSB   = 4;
  localparam int          L2_LSB   = 2;

  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_PAR  = 2'd1,
    MODE_SER  = 2'd2,
    MODE_AUX  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_BAD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_ONE  = 2'd1,
    LVL_TWO  = 2'd2,
    LVL_RSV  = 2'd3
  } lvl_e;

endpackage

// File: rtl/fg_level_decode.sv
module fg_level_decode
  import flash_guard_pkg::*;
(
  input  logic [CB_W-1:0] cb_i,
  output lvl_e            lvl_o,
  output logic            prot_o
);

  logic l1_req;
  logic l2_req;
  logic rm_clear;

  always_comb begin
    l1_req   = (cb_i[L1_LSB +: 2] != 2'b11);
    l2_req   = (cb_i[L2_LSB +: 2] != 2'b11);
    rm_clear = (cb_i[RM_LSB +: 2] == 2'b00);
    if (rm_clear)    lvl_o = LVL_NONE;
    else if (l2_req) lvl_o = LVL_TWO;
    else if (l1_req) lvl_o = LVL_ONE;
    else             lvl_o = LVL_NONE;
    prot_o = (lvl_o != LVL_NONE);
  end

endmodule

// File: rtl/fg_ctrl_reg.sv
module fg_ctrl_reg
  import flash_guard_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [CB_W-1:0] wdata_i,
  input  mode_e           mode_i,
  input  logic            prot_i,
  output logic [CB_W-1:0] ctrl_o,
  output logic            rej_o
);

  logic [CB_W-1:0] ctrl_q, ctrl_d;
  logic            rej_q, rej_d;
  logic            ctrl_en;
  logic            rm_change;
  logic            lock;

  always_comb begin
    rm_change = (wdata_i[RM_LSB +: 2] != ctrl_q[RM_LSB +: 2]);
    lock      = (mode_i == MODE_PAR) && prot_i && rm_change;
    ctrl_en   = we_i && !lock;
    ctrl_d    = wdata_i | RSV_MASK;
    rej_d     = we_i && lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CB_RESET;
      rej_q  <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      rej_q <= rej_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign rej_o  = rej_q;

endmodule

// File: rtl/fg_access_gate.sv
module fg_access_gate
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tester_i,
  input  mode_e             mode_i,
  input  lvl_e              lvl_i,
  output logic              rd_o,
  output logic              prog_o,
  output logic              erase_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              deny_o
);

  logic              refuse;
  logic              pass;
  logic              rd_d, prog_d, erase_d, deny_d;
  logic              addr_en, wdata_en;
  logic              rd_q, prog_q, erase_q, deny_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    refuse = ((mode_i == MODE_PAR) && (lvl_i != LVL_NONE))
          || ((lvl_i == LVL_TWO) && tester_i && (op_i == OP_READ))
          || (op_i == OP_BAD);
    pass     = valid_i && !refuse;
    rd_d     = pass && (op_i == OP_READ);
    prog_d   = pass && (op_i == OP_PROG);
    erase_d  = pass && (op_i == OP_ERASE);
    deny_d   = valid_i && refuse;
    addr_en  = pass;
    wdata_en = prog_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      deny_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      rd_q    <= rd_d;
      prog_q  <= prog_d;
      erase_q <= erase_d;
      deny_q  <= deny_d;
      if (addr_en)  addr_q  <= addr_i;
      if (wdata_en) wdata_q <= wdata_i;
    end
  end

  assign rd_o    = rd_q;
  assign prog_o  = prog_q;
  assign erase_o = erase_q;
  assign deny_o  = deny_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_tester_i,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic [DATA_W-1:0] fl_rdata_i,
  output logic              fl_rd_o,
  output logic              fl_prog_o,
  output logic              fl_erase_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0] fl_wdata_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              deny_o,
  output logic              cfg_rej_o,
  output logic [7:0]        ctrl_o,
  output logic [1:0]        level_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   srst_n;
  logic [CB_W-1:0]        ctrl_w;
  lvl_e                   lvl_w;
  logic                   prot_w;
  mode_e                  mode_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = rst_sync_q[SYNC_STAGES-1];

  assign mode_w = mode_e'(mode_i);

  fg_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (srst_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .mode_i  (mode_w),
    .prot_i  (prot_w),
    .ctrl_o  (ctrl_w),
    .rej_o   (cfg_rej_o)
  );

  fg_level_decode u_dec (
    .cb_i   (ctrl_w),
    .lvl_o  (lvl_w),
    .prot_o (prot_w)
  );

  fg_access_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk      (clk),
    .rst_n    (srst_n),
    .valid_i  (req_valid_i),
    .op_i     (op_e'(req_op_i)),
    .addr_i   (req_addr_i),
    .wdata_i  (req_wdata_i),
    .tester_i (req_tester_i),
    .mode_i   (mode_w),
    .lvl_i    (lvl_w),
    .rd_o     (fl_rd_o),
    .prog_o   (fl_prog_o),
    .erase_o  (fl_erase_o),
    .addr_o   (fl_addr_o),
    .wdata_o  (fl_wdata_o),
    .deny_o   (deny_o)
  );

  assign rsp_rdata_o = fl_rd_o ? fl_rdata_i : {DATA_W{1'b1}};
  assign ctrl_o      = ctrl_w;
  assign level_o     = lvl_w;

endmodule

// File: rtl/fg_checker.sv
module fg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       req_valid_i,
  input logic [1:0] req_op_i,
  input logic       req_tester_i,
  input logic       cfg_we_i,
  input logic [7:0] cfg_wdata_i,
  input logic [7:0] ctrl_o,
  input logic [1:0] level_o,
  input logic       deny_o,
  input logic       fl_rd_o,
  input logic       fl_prog_o,
  input logic       fl_erase_o
);

  // R6
  exclusive_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({deny_o, fl_rd_o, fl_prog_o, fl_erase_o}));

  // R9
  reserved_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[1:0] == 2'b11);

  // R2
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_o != 2'd3);

  // R4
  parallel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && mode_i == 2'd1 && level_o != 2'd0) |=> (deny_o && !fl_rd_o));

  // R5
  tester_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_op_i == 2'd0 && req_tester_i && level_o == 2'd2) |=> deny_o);

  // R8
  removal_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && mode_i == 2'd1 && level_o != 2'd0 && cfg_wdata_i[5:4] != ctrl_o[5:4])
      |=> $stable(ctrl_o));

endmodule

bind flash_guard fg_checker u_chk (
  .clk          (clk),
  .rst_n        (srst_n),
  .mode_i       (mode_i),
  .req_valid_i  (req_valid_i),
  .req_op_i     (req_op_i),
  .req_tester_i (req_tester_i),
  .cfg_we_i     (cfg_we_i),
  .cfg_wdata_i  (cfg_wdata_i),
  .ctrl_o       (ctrl_o),
  .level_o      (level_o),
  .deny_o       (deny_o),
  .fl_rd_o      (fl_rd_o),
  .fl_prog_o    (fl_prog_o),
  .fl_erase_o   (fl_erase_o)
);

// File: tb/flash_guard_bench.sv
module flash_guard_bench;

  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode_i;
  logic          req_valid_i;
  logic [1:0]    req_op_i;
  logic [AW-1:0] req_addr_i;
  logic [DW-1:0] req_wdata_i;
  logic          req_tester_i;
  logic          cfg_we_i;
  logic [7:0]    cfg_wdata_i;
  logic [DW-1:0] fl_rdata_i;
  logic          fl_rd_o, fl_prog_o, fl_erase_o;
  logic [AW-1:0] fl_addr_o;
  logic [DW-1:0] fl_wdata_o;
  logic [DW-1:0] rsp_rdata_o;
  logic          deny_o, cfg_rej_o;
  logic [7:0]    ctrl_o;
  logic [1:0]    level_o;

  typedef struct {
    logic          deny, rd, prog, erase;
    logic [7:0]    rdata;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    string         tag;
  } exp_t;

  exp_t        scb[$];
  int          checks = 0;
  int          errors = 0;
  logic [7:0]  model_cb;
  bit          done = 0;

  always #5 clk = ~clk;

  assign fl_rdata_i = fl_addr_o[7:0] ^ 8'h3C;

  flash_guard #(.ADDR_W(AW), .DATA_W(DW)) u_flash_guard (.*);

  function automatic logic [1:0] exp_level(logic [7:0] b);
    if (b[5:4] == 2'b00) return 2'd0;
    if (b[3:2] != 2'b11) return 2'd2;
    if (b[7:6] != 2'b11) return 2'd1;
    return 2'd0;
  endfunction

  task automatic check(bit ok, string tag, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic send(logic [1:0] mode, logic [1:0] op, logic [AW-1:0] addr,
                      logic [DW-1:0] wd, logic tester, string tag);
    exp_t e;
    logic [1:0] lv;
    logic refuse;
    @(negedge clk);
    mode_i = mode; req_valid_i = 1'b1; req_op_i = op; req_addr_i = addr;
    req_wdata_i = wd; req_tester_i = tester;
    lv = exp_level(model_cb);
    refuse = (mode == 2'd1 && lv != 2'd0) || (lv == 2'd2 && tester && op == 2'd0)
          || (op == 2'd3);
    e.deny  = refuse;
    e.rd    = !refuse && op == 2'd0;
    e.prog  = !refuse && op == 2'd1;
    e.erase = !refuse && op == 2'd2;
    e.rdata = e.rd ? (addr[7:0] ^ 8'h3C) : 8'hFF;
    e.addr  = addr;
    e.wdata = wd;
    e.tag   = tag;
    scb.push_back(e);
    @(posedge clk);
    #1 req_valid_i = 1'b0;
  endtask

  task automatic cfg(logic [1:0] mode, logic [7:0] wd, string tag);
    logic accept;
    @(negedge clk);
    mode_i = mode; cfg_we_i = 1'b1; cfg_wdata_i = wd;
    accept = !(mode == 2'd1 && exp_level(model_cb) != 2'd0 && wd[5:4] != model_cb[5:4]);
    if (accept) model_cb = wd | 8'h03;
    @(posedge clk);
    #1 cfg_we_i = 1'b0;
    #1;
    check(ctrl_o == model_cb && level_o == exp_level(model_cb) && cfg_rej_o == !accept, tag,
          $sformatf("ctrl=%h lvl=%0d rej=%b exp ctrl=%h lvl=%0d rej=%b",
                    ctrl_o, level_o, cfg_rej_o, model_cb, exp_level(model_cb), !accept));
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (scb.size() > 0) begin
        exp_t e;
        bit ok;
        e = scb.pop_front();
        ok = deny_o == e.deny && fl_rd_o == e.rd && fl_prog_o == e.prog &&
             fl_erase_o == e.erase && rsp_rdata_o == e.rdata;
        if (!e.deny) ok = ok && fl_addr_o == e.addr;
        if (e.prog)  ok = ok && fl_wdata_o == e.wdata;
        check(ok, e.tag,
              $sformatf("deny=%b rd=%b pg=%b er=%b rdata=%h addr=%h wd=%h exp deny=%b rd=%b pg=%b er=%b rdata=%h addr=%h wd=%h",
                        deny_o, fl_rd_o, fl_prog_o, fl_erase_o, rsp_rdata_o, fl_addr_o, fl_wdata_o,
                        e.deny, e.rd, e.prog, e.erase, e.rdata, e.addr, e.wdata));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_i = 2'd0; req_valid_i = 1'b0; req_op_i = 2'd0;
    req_addr_i = '0; req_wdata_i = '0; req_tester_i = 1'b0;
    cfg_we_i = 1'b0; cfg_wdata_i = '0; model_cb = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(ctrl_o == 8'hFF && level_o == 2'd0 && !deny_o && !cfg_rej_o &&
          !fl_rd_o && !fl_prog_o && !fl_erase_o, "R1",
          $sformatf("ctrl=%h lvl=%0d deny=%b rej=%b exp ctrl=ff lvl=0 all low",
                    ctrl_o, level_o, deny_o, cfg_rej_o));

    send(2'd0, 2'd0, 16'h0012, 8'h00, 1'b0, "R7 user read unprotected");
    send(2'd1, 2'd0, 16'h1234, 8'h00, 1'b0, "R4 parallel read unprotected");
    send(2'd1, 2'd1, 16'h0200, 8'hA5, 1'b0, "R7 parallel program unprotected");
    cfg(2'd1, 8'h3F, "R2 level1 via first field");
    send(2'd1, 2'd0, 16'h0040, 8'h00, 1'b0, "R4 R6 parallel read at level1");
    send(2'd1, 2'd2, 16'h0041, 8'h00, 1'b0, "R4 parallel erase at level1");
    send(2'd2, 2'd1, 16'h0301, 8'h5A, 1'b0, "R7 serial program at level1");
    send(2'd0, 2'd0, 16'h0077, 8'h00, 1'b1, "R5 tester read at level1");
    cfg(2'd2, 8'hF0, "R9 reserved forced, level2");
    send(2'd0, 2'd0, 16'h0088, 8'h00, 1'b1, "R5 tester read at level2");
    send(2'd2, 2'd0, 16'h0089, 8'h00, 1'b1, "R5 serial tester read at level2");
    send(2'd0, 2'd0, 16'h008A, 8'h00, 1'b0, "R7 plain read at level2");
    cfg(2'd1, 8'h33, "R2 both fields level2 wins, parallel no removal change");
    cfg(2'd1, 8'h03, "R8 parallel removal change locked");
    send(2'd3, 2'd2, 16'h0500, 8'h00, 1'b0, "R7 aux erase");
    send(2'd0, 2'd3, 16'h0501, 8'h00, 1'b0, "R7 op3 refused");
    cfg(2'd2, 8'h03, "R3 R8 serial removal accepted");
    send(2'd1, 2'd0, 16'h00C3, 8'h00, 1'b0, "R3 parallel read after removal");
    send(2'd0, 2'd0, 16'h00C4, 8'h00, 1'b1, "R3 tester read after removal");
    cfg(2'd1, 8'h3F, "R8 parallel removal change while unprotected");
    send(2'd1, 2'd1, 16'h0600, 8'h11, 1'b0, "R4 parallel program at level1");
    repeat (3) @(negedge clk);
    check(scb.size() == 0, "R6", $sformatf("queue=%0d exp 0", scb.size()));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule